// File: doc/BRIEF.md
# Cache Miss Statistics Accumulator

This block gathers event and latency statistics for a cache controller. The controller reports hits, misses, miss-holding-register (MSHR) hits and MSHR misses, each tagged with a command type. It also reports two kinds of completion. A response completes one request and carries that request's receive timestamp. A fill retires an MSHR and carries the command type and receive timestamp of the first request merged into that entry. The block keeps one saturating counter per command type for every counter class. Latency classes add the elapsed time, which is the shared time input minus the receive stamp.

Derived totals are not stored. A "demand" total covers read, write and read-exclusive. An "overall" total adds software and hardware prefetch to the demand total. Writeback is kept per command but never enters a total. Any per-command counter or total can be read through one combinational index port. A synchronous clear zeroes every counter.

Top module: `cache_stat_accum`

## Requirements
- R1: Command codes are 0 read, 1 write, 2 read-exclusive, 3 software prefetch, 4 hardware prefetch, 5 writeback. A valid event on a count port (hit, miss, MSHR hit, MSHR miss) adds one to that class's counter for its command. Codes 6 and 7 change nothing.
- R2: `rd_idx_i` = class*8 + sel, with classes 0 hit, 1 miss, 2 MSHR hit, 3 MSHR miss, 4 miss latency, 5 MSHR miss latency, 6 uncacheable latency. Sel 0..5 returns the per-command counter. `rd_data_o` follows the index combinationally. Class 7 returns zero.
- R3: Sel 6 returns the demand total, the sum of commands 0, 1 and 2 of that class.
- R4: Sel 7 returns the overall total, the demand total plus commands 3 and 4. Writeback (5) is excluded.
- R5: A cacheable response adds (now_i - rsp_recv_i) mod 2^TW to the miss-latency counter of its command. An uncacheable response adds nothing anywhere.
- R6: A cacheable fill adds (now_i - fill_recv_i) mod 2^TW to the MSHR-miss-latency counter of the fill's command. An uncacheable fill adds the same amount to the uncacheable-latency counter instead.
- R7: Counters and totals saturate at all ones and never wrap.
- R8: `clr_i` zeroes all counters on the next edge and overrides events in the same cycle.
- R9: Events on all six input ports in one cycle are all counted.
- R10: After reset every counter and total reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all counters |
| now_i | input | TW | Current time |
| hit_vld_i | input | 1 | Hit event |
| hit_cmd_i | input | 3 | Hit command |
| miss_vld_i | input | 1 | Miss event |
| miss_cmd_i | input | 3 | Miss command |
| mhit_vld_i | input | 1 | MSHR hit event |
| mhit_cmd_i | input | 3 | MSHR hit command |
| mmiss_vld_i | input | 1 | MSHR miss event |
| mmiss_cmd_i | input | 3 | MSHR miss command |
| rsp_vld_i | input | 1 | Per-request response |
| rsp_cmd_i | input | 3 | Response command |
| rsp_unc_i | input | 1 | Response is uncacheable |
| rsp_recv_i | input | TW | Receive time of the responding request |
| fill_vld_i | input | 1 | MSHR fill completion |
| fill_cmd_i | input | 3 | Command of the first merged request |
| fill_unc_i | input | 1 | Fill is uncacheable |
| fill_recv_i | input | TW | Receive time of the first merged request |
| rd_idx_i | input | 6 | Read index |
| rd_data_o | output | CW | Selected counter or total |

## Verification
Clear and event updates can land on the same edge. So can a response and a fill that both carry latency, alongside hits and misses on every count port. The bench drives random cycles where all six event ports are often valid together. It also runs a directed cycle with clear raised under a full set of events. After each stretch it reads all 64 indices and compares them with a reference model. In that model, clear wins and every valid port with a legal command adds its own amount.

// File: rtl/cstat_pkg.sv
package cstat_pkg;
  localparam int unsigned NUM_CMD = 6;
  localparam int unsigned NUM_CLS = 7;
  localparam int unsigned CMD_W   = 3;
  localparam int unsigned SEL_W   = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_RD   = 3'd0,
    CMD_WR   = 3'd1,
    CMD_RDX  = 3'd2,
    CMD_SWPF = 3'd3,
    CMD_HWPF = 3'd4,
    CMD_WB   = 3'd5
  } cmd_e;

  typedef enum logic [2:0] {
    CLS_HIT   = 3'd0,
    CLS_MISS  = 3'd1,
    CLS_MHIT  = 3'd2,
    CLS_MMISS = 3'd3,
    CLS_MLAT  = 3'd4,
    CLS_FLAT  = 3'd5,
    CLS_ULAT  = 3'd6
  } cls_e;

  function automatic logic is_demand(int unsigned k);
    return (k == CMD_RD) || (k == CMD_WR) || (k == CMD_RDX);
  endfunction

  function automatic logic is_nondemand(int unsigned k);
    return (k == CMD_SWPF) || (k == CMD_HWPF);
  endfunction
endpackage

// File: rtl/cstat_bank.sv
module cstat_bank #(
  parameter int unsigned CW   = 32,
  parameter int unsigned NCMD = cstat_pkg::NUM_CMD
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      vld_i,
  input  logic [cstat_pkg::CMD_W-1:0] cmd_i,
  input  logic [CW-1:0]             amt_i,
  output logic [NCMD-1:0][CW-1:0]   cnt_o
);
  localparam logic [CW-1:0] MAX = '1;

  for (genvar k = 0; k < NCMD; k++) begin : g_cmd
    logic          sel;
    logic [CW:0]   sum;
    logic [CW-1:0] nxt;

    assign sel = vld_i && (cmd_i == cstat_pkg::CMD_W'(k));
    assign sum = {1'b0, cnt_o[k]} + {1'b0, amt_i};
    assign nxt = sum[CW] ? MAX : sum[CW-1:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_o[k] <= '0;
      else if (clr_i)  cnt_o[k] <= '0;
      else if (sel)    cnt_o[k] <= nxt;
    end

    assert_clr_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_o[k] == '0));
    assert_sat_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && cnt_o[k] == MAX) |=> (cnt_o[k] == MAX));
    assert_no_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i |=> (cnt_o[k] >= $past(cnt_o[k])));
    assert_untouched_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && !(vld_i && cmd_i == cstat_pkg::CMD_W'(k))) |=> $stable(cnt_o[k]));
  end
endmodule

// File: rtl/cstat_total.sv
module cstat_total #(
  parameter int unsigned CW   = 32,
  parameter int unsigned NCMD = cstat_pkg::NUM_CMD
) (
  input  logic [NCMD-1:0][CW-1:0] cnt_i,
  output logic [CW-1:0]           dem_o,
  output logic [CW-1:0]           ovr_o
);
  localparam int unsigned SW = CW + $clog2(NCMD + 1);
  localparam logic [CW-1:0] MAX = '1;

  logic [SW-1:0] dsum, osum;

  always_comb begin
    dsum = '0;
    osum = '0;
    for (int unsigned k = 0; k < NCMD; k++) begin
      if (cstat_pkg::is_demand(k))
        dsum = dsum + SW'(cnt_i[k]);
      if (cstat_pkg::is_demand(k) || cstat_pkg::is_nondemand(k))
        osum = osum + SW'(cnt_i[k]);
    end
  end

  assign dem_o = (dsum > SW'(MAX)) ? MAX : dsum[CW-1:0];
  assign ovr_o = (osum > SW'(MAX)) ? MAX : osum[CW-1:0];
endmodule

// File: rtl/cache_stat_accum.sv
module cache_stat_accum #(
  parameter int unsigned CW = 32,
  parameter int unsigned TW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [TW-1:0] now_i,
  input  logic          hit_vld_i,
  input  logic [2:0]    hit_cmd_i,
  input  logic          miss_vld_i,
  input  logic [2:0]    miss_cmd_i,
  input  logic          mhit_vld_i,
  input  logic [2:0]    mhit_cmd_i,
  input  logic          mmiss_vld_i,
  input  logic [2:0]    mmiss_cmd_i,
  input  logic          rsp_vld_i,
  input  logic [2:0]    rsp_cmd_i,
  input  logic          rsp_unc_i,
  input  logic [TW-1:0] rsp_recv_i,
  input  logic          fill_vld_i,
  input  logic [2:0]    fill_cmd_i,
  input  logic          fill_unc_i,
  input  logic [TW-1:0] fill_recv_i,
  input  logic [5:0]    rd_idx_i,
  output logic [CW-1:0] rd_data_o
);
  import cstat_pkg::*;

  localparam int unsigned NCLS = NUM_CLS;
  localparam int unsigned NCMD = NUM_CMD;
  localparam int unsigned IW   = 3 + SEL_W;
  localparam int unsigned NIDX = 1 << IW;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [TW-1:0] rsp_dt, fill_dt;
  logic [CW-1:0] rsp_amt, fill_amt;

  assign rsp_dt  = now_i - rsp_recv_i;
  assign fill_dt = now_i - fill_recv_i;

  // Elapsed time wider than a counter clamps to the counter maximum
  if (TW > CW) begin : g_clamp
    assign rsp_amt  = (|rsp_dt[TW-1:CW])  ? '1 : rsp_dt[CW-1:0];
    assign fill_amt = (|fill_dt[TW-1:CW]) ? '1 : fill_dt[CW-1:0];
  end else begin : g_ext
    assign rsp_amt  = CW'(rsp_dt);
    assign fill_amt = CW'(fill_dt);
  end

  logic [NCLS-1:0]            c_vld;
  logic [NCLS-1:0][CMD_W-1:0] c_cmd;
  logic [NCLS-1:0][CW-1:0]    c_amt;

  always_comb begin
    c_vld[CLS_HIT]   = hit_vld_i;             c_cmd[CLS_HIT]   = hit_cmd_i;   c_amt[CLS_HIT]   = ONE;
    c_vld[CLS_MISS]  = miss_vld_i;            c_cmd[CLS_MISS]  = miss_cmd_i;  c_amt[CLS_MISS]  = ONE;
    c_vld[CLS_MHIT]  = mhit_vld_i;            c_cmd[CLS_MHIT]  = mhit_cmd_i;  c_amt[CLS_MHIT]  = ONE;
    c_vld[CLS_MMISS] = mmiss_vld_i;           c_cmd[CLS_MMISS] = mmiss_cmd_i; c_amt[CLS_MMISS] = ONE;
    c_vld[CLS_MLAT]  = rsp_vld_i & ~rsp_unc_i;   c_cmd[CLS_MLAT] = rsp_cmd_i;  c_amt[CLS_MLAT] = rsp_amt;
    c_vld[CLS_FLAT]  = fill_vld_i & ~fill_unc_i; c_cmd[CLS_FLAT] = fill_cmd_i; c_amt[CLS_FLAT] = fill_amt;
    c_vld[CLS_ULAT]  = fill_vld_i & fill_unc_i;  c_cmd[CLS_ULAT] = fill_cmd_i; c_amt[CLS_ULAT] = fill_amt;
  end

  logic [NCLS-1:0][NCMD-1:0][CW-1:0] cnt;
  logic [NCLS-1:0][CW-1:0]           dem, ovr;

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    cstat_bank #(.CW(CW), .NCMD(NCMD)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i),
      .vld_i  (c_vld[c]),
      .cmd_i  (c_cmd[c]),
      .amt_i  (c_amt[c]),
      .cnt_o  (cnt[c])
    );
    cstat_total #(.CW(CW), .NCMD(NCMD)) u_total (
      .cnt_i (cnt[c]),
      .dem_o (dem[c]),
      .ovr_o (ovr[c])
    );
  end

  logic [NIDX-1:0][CW-1:0] rdv;

  always_comb begin
    rdv = '0;
    for (int unsigned c = 0; c < NCLS; c++) begin
      for (int unsigned k = 0; k < NCMD; k++) rdv[c*8 + k] = cnt[c][k];
      rdv[c*8 + 6] = dem[c];
      rdv[c*8 + 7] = ovr[c];
    end
  end

  assign rd_data_o = rdv[rd_idx_i];

  assert_tot_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !hit_vld_i) |=> ($stable(dem[CLS_HIT]) && $stable(ovr[CLS_HIT])));
  assert_unc_split_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && (!fill_vld_i || fill_unc_i)) |=> $stable(cnt[CLS_FLAT]));
  assert_unc_rsp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && (!rsp_vld_i || rsp_unc_i)) |=> $stable(cnt[CLS_MLAT]));
endmodule

// File: tb/cache_stat_accum_tb.sv
`timescale 1ns/10ps
module cache_stat_accum_tb;
  localparam longint unsigned MAXV = 64'hFFFF_FFFF;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_i = 1'b0;
  logic [31:0] now_i = '0;
  logic        hit_vld_i = 0, miss_vld_i = 0, mhit_vld_i = 0, mmiss_vld_i = 0;
  logic [2:0]  hit_cmd_i = 0, miss_cmd_i = 0, mhit_cmd_i = 0, mmiss_cmd_i = 0;
  logic        rsp_vld_i = 0, rsp_unc_i = 0, fill_vld_i = 0, fill_unc_i = 0;
  logic [2:0]  rsp_cmd_i = 0, fill_cmd_i = 0;
  logic [31:0] rsp_recv_i = '0, fill_recv_i = '0;
  logic [5:0]  rd_idx_i = '0;
  logic [31:0] rd_data_o;

  cache_stat_accum u_dut (.*);

  always #2.5 clk_i = ~clk_i;

  int errors = 0;
  int checks = 0;
  longint unsigned mdl [7][6];
  logic done = 1'b0;

  function automatic longint unsigned clamp(longint unsigned v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  function automatic longint unsigned exp_val(int idx);
    int c = idx / 8;
    int s = idx % 8;
    if (c >= 7) return 0;
    if (s < 6) return mdl[c][s];
    if (s == 6) return clamp(mdl[c][0] + mdl[c][1] + mdl[c][2]);
    return clamp(mdl[c][0] + mdl[c][1] + mdl[c][2] + mdl[c][3] + mdl[c][4]);
  endfunction

  function automatic string tag(int idx);
    int c = idx / 8;
    int s = idx % 8;
    if (c >= 7) return "R2";
    if (s == 6) return "R3";
    if (s == 7) return "R4";
    if (c == 4) return "R5";
    if (c >= 5) return "R6";
    return "R1";
  endfunction

  task automatic add(int c, logic [2:0] cmd, longint unsigned amt);
    if (cmd < 6) mdl[c][cmd] = clamp(mdl[c][cmd] + amt);
  endtask

  task automatic model_update();
    logic [31:0] rd, fd;
    rd = now_i - rsp_recv_i;
    fd = now_i - fill_recv_i;
    if (clr_i) begin
      foreach (mdl[c, k]) mdl[c][k] = 0;
    end else begin
      if (hit_vld_i)   add(0, hit_cmd_i, 1);
      if (miss_vld_i)  add(1, miss_cmd_i, 1);
      if (mhit_vld_i)  add(2, mhit_cmd_i, 1);
      if (mmiss_vld_i) add(3, mmiss_cmd_i, 1);
      if (rsp_vld_i && !rsp_unc_i) add(4, rsp_cmd_i, rd);
      if (fill_vld_i) add(fill_unc_i ? 6 : 5, fill_cmd_i, fd);
    end
  endtask

  task automatic idle();
    clr_i = 0; hit_vld_i = 0; miss_vld_i = 0; mhit_vld_i = 0; mmiss_vld_i = 0;
    rsp_vld_i = 0; fill_vld_i = 0;
  endtask

  // inputs are set at negedge before calling; apply them over one edge
  task automatic cycle();
    @(posedge clk_i);
    model_update();
    @(negedge clk_i);
    idle();
  endtask

  task automatic check_all(string ctx);
    for (int idx = 0; idx < 64; idx++) begin
      rd_idx_i = 6'(idx);
      #0.03;
      checks++;
      if (64'(rd_data_o) != exp_val(idx)) begin
        errors++;
        $display("FAIL %s %s idx=%0d actual=%0h expected=%0h",
                 ctx, tag(idx), idx, rd_data_o, exp_val(idx));
      end
    end
  endtask

  task automatic rand_cycle();
    hit_vld_i = 1'($urandom_range(0, 1));   hit_cmd_i = 3'($urandom_range(0, 7));
    miss_vld_i = 1'($urandom_range(0, 1));  miss_cmd_i = 3'($urandom_range(0, 7));
    mhit_vld_i = 1'($urandom_range(0, 1));  mhit_cmd_i = 3'($urandom_range(0, 7));
    mmiss_vld_i = 1'($urandom_range(0, 1)); mmiss_cmd_i = 3'($urandom_range(0, 7));
    rsp_vld_i = 1'($urandom_range(0, 1));   rsp_cmd_i = 3'($urandom_range(0, 7));
    rsp_unc_i = 1'($urandom_range(0, 3) == 0);
    fill_vld_i = 1'($urandom_range(0, 1));  fill_cmd_i = 3'($urandom_range(0, 7));
    fill_unc_i = 1'($urandom_range(0, 2) == 0);
    now_i = now_i + 32'd1;
    rsp_recv_i = now_i - 32'($urandom_range(0, 500));
    fill_recv_i = now_i - 32'($urandom_range(0, 500));
    cycle();
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd7151));
    foreach (mdl[c, k]) mdl[c][k] = 0;
    repeat (3) @(negedge clk_i);
    check_all("R10 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R10 after release");

    // R9: every port valid in one cycle, mixed demand/non-demand/writeback
    hit_vld_i = 1; hit_cmd_i = 0; miss_vld_i = 1; miss_cmd_i = 3;
    mhit_vld_i = 1; mhit_cmd_i = 5; mmiss_vld_i = 1; mmiss_cmd_i = 2;
    now_i = 32'd1000;
    rsp_vld_i = 1; rsp_cmd_i = 1; rsp_unc_i = 0; rsp_recv_i = 32'd940;
    fill_vld_i = 1; fill_cmd_i = 4; fill_unc_i = 0; fill_recv_i = 32'd880;
    cycle();
    check_all("R9 concurrent");

    // R1 codes 6/7 ignored, R5 uncacheable response ignored, R6 uncacheable fill split
    hit_vld_i = 1; hit_cmd_i = 6; miss_vld_i = 1; miss_cmd_i = 7;
    rsp_vld_i = 1; rsp_cmd_i = 0; rsp_unc_i = 1; rsp_recv_i = 32'd10;
    fill_vld_i = 1; fill_cmd_i = 5; fill_unc_i = 1; fill_recv_i = 32'd990;
    cycle();
    check_all("R1/R5/R6 ignore and split");

    // R5 time wrap: elapsed taken modulo 2^32
    now_i = 32'd5;
    rsp_vld_i = 1; rsp_cmd_i = 2; rsp_unc_i = 0; rsp_recv_i = 32'hFFFF_FFFE;
    cycle();
    check_all("R5 wrap");

    for (int i = 0; i < 300; i++) begin
      rand_cycle();
      if (i % 60 == 59) check_all("R9 random");
    end

    // R7 saturation of counters and totals
    for (int i = 0; i < 2; i++) begin
      now_i = 32'hF000_0000;
      fill_vld_i = 1; fill_unc_i = 0; fill_cmd_i = 3'(i); fill_recv_i = '0;
      rsp_vld_i = 1; rsp_unc_i = 0; rsp_cmd_i = 3'(i + 3); rsp_recv_i = '0;
      cycle();
      fill_vld_i = 1; fill_unc_i = 0; fill_cmd_i = 3'(i); fill_recv_i = '0;
      rsp_vld_i = 1; rsp_unc_i = 0; rsp_cmd_i = 3'(i + 3); rsp_recv_i = '0;
      cycle();
    end
    check_all("R7 saturate");
    fill_vld_i = 1; fill_unc_i = 0; fill_cmd_i = 0; fill_recv_i = 32'd3; now_i = 32'd9;
    cycle();
    check_all("R7 hold at max");

    // R8 clear wins over same-cycle events
    clr_i = 1;
    hit_vld_i = 1; hit_cmd_i = 1; miss_vld_i = 1; miss_cmd_i = 1;
    mhit_vld_i = 1; mhit_cmd_i = 1; mmiss_vld_i = 1; mmiss_cmd_i = 1;
    rsp_vld_i = 1; rsp_unc_i = 0; rsp_cmd_i = 1; rsp_recv_i = 32'd1;
    fill_vld_i = 1; fill_unc_i = 1; fill_cmd_i = 1; fill_recv_i = 32'd1;
    cycle();
    check_all("R8 clear");

    for (int i = 0; i < 100; i++) rand_cycle();
    check_all("R9 random after clear");

    done = 1'b1;
    summary();
  end
endmodule